// File: doc/BRIEF.md
# Cassette Port Motor Control and Pulse Replay Timer

This block sits between a processor bus and a tape pulse source. It keeps the cassette motor control bit that the processor writes through the on-chip port at address 1, and it splices that bit, together with the live play-button level, into the byte the processor reads back from that address. Every other address returns the RAM byte untouched.

The same block replays tape pulses. A down-counter is loaded with a pulse length supplied by an upstream fetcher. It counts one step per clock while the motor runs, and it holds its value while the motor is off. Within each pulse the tape level is low for the first half and high for the second half. A one-cycle flag is produced on every rising edge of that level, so the interrupt logic downstream sees an edge event rather than a level. A strobe tells the fetcher that a length has just been taken, so it can present the next one.

Top module: `cas_tape_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `motor_off` is 1 (motor stopped), and the byte read at address 1 carries 1 in bit 5.
- R2: A clock edge with `bus_we` high and `bus_addr` equal to 1 loads `motor_off` from `bus_wdata` bit 5 (0 = run, 1 = stop). A write to any other address, or address 1 with `bus_we` low, leaves it unchanged.
- R3: When `bus_addr` is 1, `bus_rdata` is `ram_rdata` with bit 5 replaced by the motor bit and bit 4 replaced by `cas_button_n` (0 = a cassette key is held, 1 = none). Bits 7:6 and 3:0 pass through. The path is combinational.
- R4: For any address other than 1, `bus_rdata` equals `ram_rdata`.
- R5: Reset clears the pulse counter, so `tape_level`, `tape_flag` and `load_strobe` are 0 during reset and on the first cycle after it.
- R6: On an edge where the counter is zero, the counter is loaded from `pulse_len`. `load_strobe` is high for exactly the following cycle.
- R7: On an edge where the counter is nonzero, it decrements by one if the motor bit is 0 and holds its value if the motor bit is 1. Level, flag and strobe therefore stay frozen while the motor is stopped.
- R8: `tape_level` is 1 when the counter is nonzero and at most half (rounded down) of the length last loaded. Otherwise it is 0.
- R9: `tape_flag` is 1 for exactly one cycle, the first cycle in which `tape_level` is 1 after a cycle in which it was 0.
- R10: A reload from a zero count happens whether or not the motor is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Processor address |
| bus_we | input | 1 | Processor write enable |
| bus_wdata | input | 8 | Processor write data |
| ram_rdata | input | 8 | RAM byte at the current address |
| cas_button_n | input | 1 | Play-button sense, 0 when a key is held |
| bus_rdata | output | 8 | Byte returned to the processor |
| motor_off | output | 1 | Motor control bit, 1 = stopped |
| pulse_len | input | CNT_W | Next pulse length from the fetcher |
| load_strobe | output | 1 | One cycle after each reload |
| tape_level | output | 1 | Replayed tape level |
| tape_flag | output | 1 | One-cycle pulse on each rising edge of the level |

## Verification
The bench builds the block with a counter width of 8 and the default 16-bit address. With that width, the largest pulse length of 255 and its reload fit into a few hundred cycles, next to lengths of 0, 1 and 2, where the half-pulse rule and back-to-back reloads meet. The bench stops the motor in the middle of a pulse and also straight after reset while the count is still zero. This covers both the freeze and the reload that happens even with the motor stopped. Reads and writes go to address 1 and to nearby addresses, so the splicing and the write decode can be told apart.

// File: rtl/cas_pkg.sv
package cas_pkg;

    localparam int PORT_BYTE_W = 8;
    localparam int MOTOR_POS   = 5;
    localparam int BUTTON_POS  = 4;

    typedef logic [PORT_BYTE_W-1:0] port_byte_t;

    // Write request already decoded against the port address
    typedef struct packed {
        logic       hit;
        port_byte_t data;
    } port_wr_t;

    // Observable tape events produced by the replay path
    typedef struct packed {
        logic level;
        logic flag;
        logic strobe;
    } tape_ev_t;

    function automatic port_byte_t splice_port(port_byte_t ram, logic motor, logic button);
        port_byte_t r;
        r             = ram;
        r[MOTOR_POS]  = motor;
        r[BUTTON_POS] = button;
        return r;
    endfunction

endpackage

// File: rtl/cas_motor_latch.sv
module cas_motor_latch
    import cas_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  port_wr_t wr,
    output logic     motor_off
);

    logic motor_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            motor_q <= 1'b1;
        end else if (wr.hit) begin
            motor_q <= wr.data[MOTOR_POS];
        end
    end

    assign motor_off = motor_q;

    // R2: a decoded write loads the motor bit from the data byte
    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr.hit |=> (motor_q == $past(wr.data[MOTOR_POS])));

    // R2: without a decoded write the motor bit holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr.hit |=> $stable(motor_q));

endmodule

// File: rtl/cas_port_read.sv
module cas_port_read
    import cas_pkg::*;
(
    input  logic       port_sel,
    input  port_byte_t ram_byte,
    input  logic       motor_off,
    input  logic       button_n,
    output port_byte_t rd_byte
);

    always_comb begin
        if (port_sel) begin
            rd_byte = splice_port(ram_byte, motor_off, button_n);
        end else begin
            rd_byte = ram_byte;
        end
    end

endmodule

// File: rtl/cas_pulse_timer.sv
module cas_pulse_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             motor_off,
    input  logic [CNT_W-1:0] pulse_len,
    output logic             level,
    output logic             load_strobe
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] held_q;
    logic             strobe_q;
    logic             at_zero;
    logic [CNT_W-1:0] half_len;

    assign at_zero  = (cnt_q == '0);
    assign half_len = held_q >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            held_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= at_zero;
            if (at_zero) begin
                cnt_q  <= pulse_len;
                held_q <= pulse_len;
            end else if (!motor_off) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign level       = !at_zero && (cnt_q <= half_len);
    assign load_strobe = strobe_q;

    // R6 and R10: a zero count reloads from the supplied length and strobes next cycle
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        at_zero |=> ((cnt_q == $past(pulse_len)) && load_strobe));

    // R7: the count freezes while the motor is stopped
    a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
        (motor_off && !at_zero) |=> $stable(cnt_q));

    // R7: the count steps down by one while the motor runs
    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        (!motor_off && !at_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/cas_edge_flag.sv
module cas_edge_flag (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic flag
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    assign flag = level & ~prev_q;

    // R9: the flag never stays high for two cycles in a row
    a_r9_single: assert property (@(posedge clk) disable iff (rst)
        flag |=> !flag);

endmodule

// File: rtl/cas_tape_port.sv
module cas_tape_port
    import cas_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int PORT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic              cas_button_n,
    output logic [7:0]        bus_rdata,
    output logic              motor_off,
    input  logic [CNT_W-1:0]  pulse_len,
    output logic              load_strobe,
    output logic              tape_level,
    output logic              tape_flag
);

    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_ADDR);

    logic     port_sel;
    port_wr_t wr;
    tape_ev_t ev;

    assign port_sel = (bus_addr == PORT_A);
    assign wr.hit   = port_sel && bus_we;
    assign wr.data  = bus_wdata;

    cas_motor_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .motor_off (motor_off)
    );

    cas_port_read u_read (
        .port_sel  (port_sel),
        .ram_byte  (ram_rdata),
        .motor_off (motor_off),
        .button_n  (cas_button_n),
        .rd_byte   (bus_rdata)
    );

    cas_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .motor_off   (motor_off),
        .pulse_len   (pulse_len),
        .level       (ev.level),
        .load_strobe (ev.strobe)
    );

    cas_edge_flag u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (ev.level),
        .flag  (ev.flag)
    );

    assign tape_level  = ev.level;
    assign tape_flag   = ev.flag;
    assign load_strobe = ev.strobe;

    // R3: the read path at the port address carries motor and button bits
    a_r3_splice: assert property (@(posedge clk) disable iff (rst)
        port_sel |-> ((bus_rdata[5] == motor_off) && (bus_rdata[4] == cas_button_n)));

endmodule

// File: tb/cas_tape_port_bench.sv
module cas_tape_port_bench;

    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    ram_rdata = '0;
    logic          cas_button_n = 1'b1;
    logic [CW-1:0] pulse_len = '0;
    logic [7:0]    bus_rdata;
    logic          motor_off, load_strobe, tape_level, tape_flag;

    always #5 clk = ~clk;

    cas_tape_port #(.ADDR_W(AW), .CNT_W(CW), .PORT_ADDR(1)) u_cas_tape_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .ram_rdata(ram_rdata), .cas_button_n(cas_button_n),
        .bus_rdata(bus_rdata), .motor_off(motor_off), .pulse_len(pulse_len),
        .load_strobe(load_strobe), .tape_level(tape_level), .tape_flag(tape_flag)
    );

    typedef struct {
        logic [7:0] rd;
        logic       motor_off;
        logic       level;
        logic       flag;
        logic       strobe;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;
    event chk_ev;

    // Reference state written from the requirements
    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_held = '0;
    logic          m_motor = 1'b1;
    logic          m_prev = 1'b0;
    logic          m_strobe = 1'b0;
    logic [CW-1:0] cur_len = '0;
    logic          cur_btn = 1'b1;

    function automatic logic m_level();
        return (m_cnt != '0) && (m_cnt <= (m_held >> 1));
    endfunction

    task automatic drive(input logic r, input logic [AW-1:0] a, input logic w,
                         input logic [7:0] wd, input logic [7:0] ram);
        exp_t e;
        logic lv;
        rst = r; bus_addr = a; bus_we = w; bus_wdata = wd;
        ram_rdata = ram; cas_button_n = cur_btn; pulse_len = cur_len;
        e.rd        = (a == AW'(1)) ? {ram[7:6], m_motor, cur_btn, ram[3:0]} : ram;
        e.motor_off = m_motor;
        e.level     = m_level();
        e.flag      = m_level() & ~m_prev;
        e.strobe    = m_strobe;
        q.push_back(e);
        ->chk_ev;
        @(posedge clk);
        if (r) begin
            m_cnt = '0; m_held = '0; m_motor = 1'b1; m_prev = 1'b0; m_strobe = 1'b0;
        end else begin
            lv = m_level();
            m_strobe = (m_cnt == '0);
            if (m_cnt == '0) begin
                m_cnt = cur_len; m_held = cur_len;
            end else if (!m_motor) begin
                m_cnt = m_cnt - 1'b1;
            end
            m_prev = lv;
            if (w && a == AW'(1)) m_motor = wd[5];
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 16'h0040, 1'b0, 8'h00, 8'h3C);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        drive(1'b0, a, 1'b1, d, 8'h00);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] ram);
        drive(1'b0, a, 1'b0, 8'h00, ram);
    endtask

    // Monitor: pops the expectation and compares it against the ports
    always @(chk_ev) begin
        exp_t e;
        bit bad;
        #1;
        e = q.pop_front();
        bad = 1'b0;
        vectors++;
        if (motor_off !== e.motor_off) begin
            bad = 1'b1;
            $display("FAIL R1/R2 motor_off actual=%b expected=%b t=%0t", motor_off, e.motor_off, $time);
        end
        if (bus_rdata !== e.rd) begin
            bad = 1'b1;
            $display("FAIL R3/R4 bus_rdata actual=%h expected=%h t=%0t", bus_rdata, e.rd, $time);
        end
        if (tape_level !== e.level) begin
            bad = 1'b1;
            $display("FAIL R8/R7 tape_level actual=%b expected=%b t=%0t", tape_level, e.level, $time);
        end
        if (tape_flag !== e.flag) begin
            bad = 1'b1;
            $display("FAIL R9 tape_flag actual=%b expected=%b t=%0t", tape_flag, e.flag, $time);
        end
        if (load_strobe !== e.strobe) begin
            bad = 1'b1;
            $display("FAIL R6/R10 load_strobe actual=%b expected=%b t=%0t", load_strobe, e.strobe, $time);
        end
        if (bad) miscompares++;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R5, R1: reset state
        for (int i = 0; i < 3; i++) drive(1'b1, 16'h0001, 1'b0, 8'h00, 8'hFF);
        // R10: motor stopped, zero count still reloads, then freezes (R7)
        cur_len = 8'd6;
        drive(1'b0, 16'h0001, 1'b0, 8'h00, 8'h00);
        idle(5);
        // R3: splice with both button levels
        rd(16'h0001, 8'hA5);
        cur_btn = 1'b0; rd(16'h0001, 8'h5A); rd(16'h0001, 8'hFF);
        cur_btn = 1'b1; rd(16'h0001, 8'h00);
        // R4: neighbouring addresses pass RAM through
        rd(16'h0000, 8'hC3); rd(16'h0002, 8'h7E); rd(16'h0101, 8'h10);
        // R2: ignored writes: wrong address, and we low at the port
        wr(16'h0000, 8'h00); wr(16'h0101, 8'h00);
        drive(1'b0, 16'h0001, 1'b0, 8'h00, 8'h00);
        rd(16'h0001, 8'h00);
        // R2: start the motor, pulses run (R6, R8, R9)
        wr(16'h0001, 8'hDF);
        idle(30);
        // R7: stop mid-pulse, then restart
        wr(16'h0001, 8'h20);
        idle(8);
        rd(16'h0001, 8'h11);
        wr(16'h0001, 8'h00);
        idle(12);
        // R6: changing lengths, including 0, 1, 2 and the maximum
        cur_len = 8'd2; idle(9);
        cur_len = 8'd1; idle(6);
        cur_len = 8'd0; idle(5);
        cur_len = 8'd3; idle(10);
        cur_len = 8'd255; idle(520);
        // R5: reset in the middle of a pulse
        cur_len = 8'd9; idle(4);
        drive(1'b1, 16'h0001, 1'b0, 8'h00, 8'h00);
        drive(1'b1, 16'h0001, 1'b0, 8'h00, 8'h00);
        rd(16'h0001, 8'h00);
        wr(16'h0001, 8'h00);
        idle(25);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule